// File: doc/BRIEF.md
# Integer ALU with Status Flags

This block is the integer arithmetic and logic stage of a processor datapath. It handles nine operations on 8-, 16- or 32-bit operands: add, add with carry, subtract, subtract with borrow, increment, decrement, AND, OR and XOR. For each operation it returns the result and six status flags: carry, parity, auxiliary (nibble) carry, zero, sign and overflow. It also returns a write-enable mask, so the enclosing core knows which of its stored flags each operation may update.

The caller presents an opcode, a size select, a destination operand, a source operand and a carry input, and pulses `in_valid` for one cycle. One clock edge later, `out_valid` rises and the registered result, flags and mask appear. Those outputs hold until the next valid cycle. The flag rules depend on the operand size:
- Carry and overflow are taken at the selected width.
- Parity looks only at the low byte of the result.
- Auxiliary carry always comes from bit 4.

Top module: `intalu_flags`

## Requirements
- R1: When `in_valid` is high at a rising edge, `out_valid`, `result`, `flags` and `flag_we` update at that edge. `out_valid` is high in exactly the cycle after a valid input. When `in_valid` is low, `result`, `flags` and `flag_we` keep their values and `out_valid` is low.
- R2: While `rst_n` is low, every output is zero.
- R3: `size_sel` 2'b00 selects 8 bits, 2'b01 selects 16 bits, and 2'b10 or 2'b11 selects 32 bits. Operand bits above the selected width are ignored, and result bits above it are zero.
- R4: The opcode encoding is 0 ADD, 1 ADC, 2 SUB, 3 SBB, 4 INC, 5 DEC, 6 AND, 7 OR and 8 XOR. Results are computed modulo 2^width. ADC adds `carry_in` and SBB subtracts it as an extra borrow; every other opcode ignores `carry_in`.
- R5: For ADD, ADC, SUB and SBB, the CF flag is the carry out of (or the borrow into) the top bit of the selected width.
- R6: OF is the signed overflow at the selected width. For additions it is set when the result's sign differs from both operands' signs. For subtractions it is set when the two operands' signs differ and the result's sign differs from the destination's sign.
- R7: AF is the carry out of, or borrow into, bit 3. This equals bit 4 of result XOR destination XOR source, at every width.
- R8: SF is the top bit of the width-truncated result. ZF is set when that result is zero. PF is set when the low 8 bits of the result hold an even number of ones.
- R9: INC and DEC add or subtract 1 and compute OF, AF, SF, ZF and PF as an add or subtract of 1. They never write CF.
- R10: AND, OR and XOR report CF = 0 and OF = 0, update SF, ZF and PF, and do not write AF.
- R11: Bit positions in `flags` and `flag_we` are: 0 CF, 1 PF, 2 AF, 3 ZF, 4 SF, 5 OF. The mask is 6'b111111 for ADD/ADC/SUB/SBB, 6'b111110 for INC/DEC and 6'b111011 for logic operations. A flag bit whose enable is 0 reads as 0.
- R12: Opcodes 9 to 15 produce a zero result, zero flags and a zero mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation request strobe |
| op | input | 4 | Opcode (see R4) |
| size_sel | input | 2 | Operand width select (see R3) |
| dst | input | 32 | Destination operand |
| src | input | 32 | Source operand |
| carry_in | input | 1 | Incoming carry or borrow for ADC and SBB |
| out_valid | output | 1 | Registered result is fresh this cycle |
| result | output | 32 | Registered width-truncated result |
| flags | output | 6 | Registered status flags (see R11) |
| flag_we | output | 6 | Registered per-flag write enables |

## Verification
The properties assume that inputs are stable around each rising edge, and that `in_valid` is a clean level rather than X. The bench drives every input at the falling edge to meet this. Opcodes 9 to 15 and size code 2'b11 are legal inputs with defined results, so the bench sweeps them on purpose rather than avoiding them. Operand bits above the selected width are filled with junk, which confirms they are ignored. Idle cycles between bursts change the inputs while `in_valid` is low, to exercise the hold behaviour.

// File: rtl/intalu_pkg.sv
package intalu_pkg;

  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_ADC = 4'd1,
    OP_SUB = 4'd2,
    OP_SBB = 4'd3,
    OP_INC = 4'd4,
    OP_DEC = 4'd5,
    OP_AND = 4'd6,
    OP_OR  = 4'd7,
    OP_XOR = 4'd8
  } alu_op_e;

  typedef enum logic [1:0] {
    CL_NONE   = 2'd0,
    CL_ADDSUB = 2'd1,
    CL_STEP   = 2'd2,
    CL_LOGIC  = 2'd3
  } op_class_e;

  localparam int NUM_FLAGS = 6;
  localparam int FL_CF = 0;
  localparam int FL_PF = 1;
  localparam int FL_AF = 2;
  localparam int FL_ZF = 3;
  localparam int FL_SF = 4;
  localparam int FL_OF = 5;

  function automatic op_class_e classify(input logic [3:0] op);
    case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBB: return CL_ADDSUB;
      OP_INC, OP_DEC:                 return CL_STEP;
      OP_AND, OP_OR, OP_XOR:          return CL_LOGIC;
      default:                        return CL_NONE;
    endcase
  endfunction

  function automatic logic [NUM_FLAGS-1:0] enables_for(input op_class_e cls);
    logic [NUM_FLAGS-1:0] en;
    en = '0;
    case (cls)
      CL_ADDSUB: en = '1;
      CL_STEP: begin
        en = '1;
        en[FL_CF] = 1'b0;
      end
      CL_LOGIC: begin
        en = '1;
        en[FL_AF] = 1'b0;
      end
      default: en = '0;
    endcase
    return en;
  endfunction

  function automatic logic subtracts(input logic [3:0] op);
    return (op == OP_SUB) || (op == OP_SBB) || (op == OP_DEC);
  endfunction

  function automatic logic takes_carry(input logic [3:0] op);
    return (op == OP_ADC) || (op == OP_SBB);
  endfunction

endpackage

// File: rtl/intalu_size_mask.sv
module intalu_size_mask #(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8
) (
  input  logic [1:0]        size_sel,
  output logic [DATA_W-1:0] mask,
  output logic [DATA_W-1:0] top_bit
);
  localparam int LANES = DATA_W / LANE_W;

  logic [LANES-1:0] lane_en;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    if (g == 0) begin : g_base
      assign lane_en[g] = 1'b1;
    end else if (g == 1) begin : g_half
      assign lane_en[g] = (size_sel != 2'b00);
    end else begin : g_word
      assign lane_en[g] = size_sel[1];
    end
    assign mask[g*LANE_W +: LANE_W] = {LANE_W{lane_en[g]}};
  end

  // one-hot marker of the sign bit of the selected width
  assign top_bit = mask & ~(mask >> 1);
endmodule

// File: rtl/intalu_addsub.sv
module intalu_addsub #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              cin,
  input  logic              sub,
  output logic [DATA_W:0]   wide
);
  localparam int WW = DATA_W + 1;

  logic [WW-1:0] ax, bx, cx;

  assign ax   = {1'b0, a};
  assign bx   = {1'b0, b};
  assign cx   = {{DATA_W{1'b0}}, cin};
  assign wide = sub ? (ax - bx - cx) : (ax + bx + cx);
endmodule

// File: rtl/intalu_flag_unit.sv
module intalu_flag_unit
  import intalu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0]    res,
  input  logic [DATA_W:0]      wide,
  input  logic [DATA_W-1:0]    a,
  input  logic [DATA_W-1:0]    b,
  input  logic [DATA_W-1:0]    top_bit,
  input  logic                 is_sub,
  input  op_class_e            cls,
  output logic                 carry_out,
  output logic                 ovf,
  output logic [NUM_FLAGS-1:0] flags_raw
);
  logic [DATA_W-1:0] ovf_vec;
  logic [DATA_W-1:0] aux_vec;
  logic              aux;
  logic              sign;
  logic              zero;
  logic              parity;

  assign carry_out = |(wide[DATA_W:1] & top_bit);
  assign ovf_vec   = is_sub ? ((a ^ b) & (a ^ res)) : ((res ^ b) & (res ^ a));
  assign ovf       = |(ovf_vec & top_bit);
  assign aux_vec   = res ^ a ^ b;
  assign aux       = aux_vec[4];
  assign sign      = |(res & top_bit);
  assign zero      = (res == '0);
  assign parity    = ~^res[7:0];

  always_comb begin
    flags_raw        = '0;
    flags_raw[FL_PF] = parity;
    flags_raw[FL_ZF] = zero;
    flags_raw[FL_SF] = sign;
    if (cls == CL_ADDSUB || cls == CL_STEP) begin
      flags_raw[FL_CF] = carry_out;
      flags_raw[FL_OF] = ovf;
      flags_raw[FL_AF] = aux;
    end
  end
endmodule

// File: rtl/intalu_flags.sv
module intalu_flags
  import intalu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [3:0]           op,
  input  logic [1:0]           size_sel,
  input  logic [DATA_W-1:0]    dst,
  input  logic [DATA_W-1:0]    src,
  input  logic                 carry_in,
  output logic                 out_valid,
  output logic [DATA_W-1:0]    result,
  output logic [NUM_FLAGS-1:0] flags,
  output logic [NUM_FLAGS-1:0] flag_we
);
  op_class_e             cls;
  logic [DATA_W-1:0]     mask, top_bit;
  logic [DATA_W-1:0]     opa, opb;
  logic                  is_sub, cin_eff;
  logic [DATA_W:0]       wide;
  logic [DATA_W-1:0]     logic_res, res_next;
  logic                  carry_out, ovf;
  logic [NUM_FLAGS-1:0]  flags_raw, we_next;

  assign cls     = classify(op);
  assign is_sub  = subtracts(op);
  assign cin_eff = takes_carry(op) & carry_in;

  intalu_size_mask #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_mask (
    .size_sel (size_sel),
    .mask     (mask),
    .top_bit  (top_bit)
  );

  assign opa = dst & mask;
  assign opb = (cls == CL_STEP) ? {{(DATA_W-1){1'b0}}, 1'b1} : (src & mask);

  intalu_addsub #(.DATA_W(DATA_W)) u_addsub (
    .a    (opa),
    .b    (opb),
    .cin  (cin_eff),
    .sub  (is_sub),
    .wide (wide)
  );

  always_comb begin
    case (op)
      OP_AND:  logic_res = opa & opb;
      OP_OR:   logic_res = opa | opb;
      OP_XOR:  logic_res = opa ^ opb;
      default: logic_res = '0;
    endcase
  end

  always_comb begin
    case (cls)
      CL_ADDSUB, CL_STEP: res_next = wide[DATA_W-1:0] & mask;
      CL_LOGIC:           res_next = logic_res;
      default:            res_next = '0;
    endcase
  end

  intalu_flag_unit #(.DATA_W(DATA_W)) u_flags (
    .res       (res_next),
    .wide      (wide),
    .a         (opa),
    .b         (opb),
    .top_bit   (top_bit),
    .is_sub    (is_sub),
    .cls       (cls),
    .carry_out (carry_out),
    .ovf       (ovf),
    .flags_raw (flags_raw)
  );

  assign we_next = enables_for(cls);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      flags     <= '0;
      flag_we   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result  <= res_next;
        flags   <= flags_raw & we_next;
        flag_we <= we_next;
      end
    end
  end
endmodule

// File: rtl/intalu_flags_chk.sv
module intalu_flags_chk
  import intalu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic [3:0]           op,
  input logic [1:0]           size_sel,
  input logic                 out_valid,
  input logic [DATA_W-1:0]    result,
  input logic [NUM_FLAGS-1:0] flags,
  input logic [NUM_FLAGS-1:0] flag_we,
  input logic                 carry_out,
  input op_class_e            cls
);
  p_valid_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_idle_holds_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(result) && $stable(flags) && $stable(flag_we)));

  p_byte_upper_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && size_sel == 2'b00) |=> ((result >> 8) == '0));

  p_half_upper_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && size_sel == 2'b01) |=> ((result >> 16) == '0));

  p_carry_reaches_cf_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cls == CL_ADDSUB) |=> (flags[FL_CF] == $past(carry_out)));

  p_zero_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && flag_we[FL_ZF]) |-> (flags[FL_ZF] == (result == '0)));

  p_parity_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && flag_we[FL_PF]) |-> (flags[FL_PF] == ($countones(result[7:0]) % 2 == 0)));

  p_step_keeps_cf_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (op == 4'd4 || op == 4'd5)) |=> (flag_we == 6'b111110));

  p_logic_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op >= 4'd6 && op <= 4'd8) |=>
      (!flags[FL_CF] && !flags[FL_OF] && !flag_we[FL_AF]));

  p_gated_flags_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((flags & ~flag_we) == '0));

  p_unused_op_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op >= 4'd9) |=> (result == '0 && flags == '0 && flag_we == '0));
endmodule

bind intalu_flags intalu_flags_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .op        (op),
  .size_sel  (size_sel),
  .out_valid (out_valid),
  .result    (result),
  .flags     (flags),
  .flag_we   (flag_we),
  .carry_out (carry_out),
  .cls       (cls)
);

// File: tb/intalu_flags_test.sv
module intalu_flags_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [3:0]  op = 4'd0;
  logic [1:0]  size_sel = 2'b00;
  logic [31:0] dst = 32'd0;
  logic [31:0] src = 32'd0;
  logic        carry_in = 1'b0;
  logic        out_valid;
  logic [31:0] result;
  logic [5:0]  flags;
  logic [5:0]  flag_we;

  int vectors = 0;
  int miscompares = 0;
  bit checking = 1'b0;
  bit done = 1'b0;
  string phase = "R2";

  logic        exp_valid = 1'b0;
  logic [31:0] exp_res = '0;
  logic [5:0]  exp_flags = '0;
  logic [5:0]  exp_we = '0;

  always #5 clk = ~clk;

  intalu_flags uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .size_sel(size_sel),
    .dst(dst), .src(src), .carry_in(carry_in), .out_valid(out_valid),
    .result(result), .flags(flags), .flag_we(flag_we)
  );

  // behavioural reference: widened signed/unsigned integers, no bit-vector tricks
  task automatic model(input logic [3:0] o, input logic [1:0] sz, input logic [31:0] d,
                       input logic [31:0] s, input logic c,
                       output logic [31:0] r, output logic [5:0] f, output logic [5:0] we);
    int     w;
    longint m, a, b, ci, full, res, half, sa, sb, sr, nib;
    bit     arith, step, lg;
    w = (sz == 2'b00) ? 8 : (sz == 2'b01) ? 16 : 32;
    m = (longint'(1) << w) - 1;
    half = longint'(1) << (w - 1);
    a = longint'(d) & m;
    b = longint'(s) & m;
    arith = (o <= 4'd3);
    step = (o == 4'd4 || o == 4'd5);
    lg = (o >= 4'd6 && o <= 4'd8);
    if (step) b = 1;
    ci = (o == 4'd1 || o == 4'd3) ? longint'(c) : 0;
    full = 0;
    nib = 0;
    case (o)
      4'd0, 4'd1, 4'd4: begin full = a + b + ci; nib = (a % 16) + (b % 16) + ci; end
      4'd2, 4'd3, 4'd5: begin full = a - b - ci; nib = (a % 16) - (b % 16) - ci; end
      4'd6: full = a & b;
      4'd7: full = a | b;
      4'd8: full = a ^ b;
      default: full = 0;
    endcase
    res = full & m;
    sa = (a >= half) ? a - 2 * half : a;
    sb = (b >= half) ? b - 2 * half : b;
    if (o == 4'd2 || o == 4'd3 || o == 4'd5) sr = sa - sb - ci;
    else sr = sa + sb + ci;
    r = 32'(res);
    f = '0;
    we = '0;
    if (arith || step || lg) begin
      we = arith ? 6'b111111 : step ? 6'b111110 : 6'b111011;
      f[1] = ($countones(res & 255) % 2) == 0;
      f[3] = (res == 0);
      f[4] = (res >= half);
      if (arith) f[0] = ((full >> w) & 1) != 0;
      if (!lg) begin
        f[5] = (sr < -half) || (sr >= half);
        f[2] = (nib < 0) || (nib >= 16);
      end
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_valid = 1'b0; exp_res = '0; exp_flags = '0; exp_we = '0;
    end else begin
      exp_valid = in_valid;
      if (in_valid) model(op, size_sel, dst, src, carry_in, exp_res, exp_flags, exp_we);
    end
  end

  task automatic report(input string field, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
    miscompares++;
    $display("FAIL %s (%s) phase %s: actual %h expected %h", req, field, phase, act, exp);
  endtask

  always @(negedge clk) begin
    if (checking && !done) begin
      vectors++;
      if (!rst_n) begin
        if ({out_valid, result, flags, flag_we} != '0)
          report("reset", "R2", {out_valid, result[18:0], flags, flag_we}, 32'd0);
      end else begin
        if (out_valid !== exp_valid) report("valid", "R1", 32'(out_valid), 32'(exp_valid));
        if (result !== exp_res) report("result", "R4", result, exp_res);
        if (flags[0] !== exp_flags[0]) report("CF", "R5", 32'(flags[0]), 32'(exp_flags[0]));
        if (flags[5] !== exp_flags[5]) report("OF", "R6", 32'(flags[5]), 32'(exp_flags[5]));
        if (flags[2] !== exp_flags[2]) report("AF", "R7", 32'(flags[2]), 32'(exp_flags[2]));
        if ({flags[4], flags[3], flags[1]} !== {exp_flags[4], exp_flags[3], exp_flags[1]})
          report("SF/ZF/PF", "R8", 32'(flags), 32'(exp_flags));
        if (flag_we !== exp_we) report("mask", "R11", 32'(flag_we), 32'(exp_we));
      end
    end
  end

  task automatic apply(input logic [3:0] o, input logic [1:0] sz, input logic [31:0] d,
                       input logic [31:0] s, input logic c);
    @(negedge clk);
    in_valid = 1'b1; op = o; size_sel = sz; dst = d; src = s; carry_in = c;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0; op = 4'($urandom); size_sel = 2'($urandom);
      dst = $urandom; src = $urandom; carry_in = 1'($urandom);
    end
  endtask

  function automatic logic [31:0] corner(input int k, input logic [1:0] sz);
    logic [31:0] m, junk;
    m = (sz == 2'b00) ? 32'hFF : (sz == 2'b01) ? 32'hFFFF : 32'hFFFF_FFFF;
    junk = 32'hC3A5_5A00 & ~m;
    case (k)
      0: return junk;
      1: return junk | 32'd1;
      2: return junk | (m >> 1);
      3: return junk | (m & ~(m >> 1));
      default: return junk | m;
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    checking = 1'b1;
    phase = "R2";
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    phase = "R1";
    idle(3);
    // boundary sweep over every opcode, width and carry
    for (int o = 0; o < 9; o++) begin
      phase = (o <= 3) ? "R4" : (o <= 5) ? "R9" : "R10";
      for (int sz = 0; sz < 3; sz++)
        for (int i = 0; i < 5; i++)
          for (int j = 0; j < 5; j++)
            for (int c = 0; c < 2; c++)
              apply(4'(o), 2'(sz), corner(i, 2'(sz)), corner(j, 2'(sz)), 1'(c));
      phase = "R1";
      idle(4);
    end
    phase = "R3";
    for (int n = 0; n < 200; n++)
      apply(4'($urandom_range(0, 8)), 2'b11, $urandom, $urandom, 1'($urandom));
    phase = "R12";
    for (int o = 9; o < 16; o++) begin
      apply(4'(o), 2'($urandom), $urandom, $urandom, 1'b1);
      idle(1);
    end
    phase = "R4";
    for (int n = 0; n < 2000; n++) begin
      apply(4'($urandom_range(0, 8)), 2'($urandom_range(0, 2)), $urandom, $urandom,
            1'($urandom));
      if (n % 97 == 0) idle(2);
    end
    phase = "R1";
    idle(5);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule